// File: doc/BRIEF.md
# PHY Lane Tuning Init Sequencer

This block brings a combined USB3/PCIe serdes lane into a tuned state after power-up. When the lane is in USB3 mode it first flips the protocol selector in a local configuration word, then walks a fixed list of five masked read-modify-write operations over a slow, handshaked control bus into the PHY, and finally updates a few analog tuning fields held in its own configuration words. Each bus step reads the PHY register, merges the new field bits into the old contents, and writes the result back only when something actually changes.

The run starts by itself once after reset is released and again whenever `start` is pulsed while the block is idle. In PCIe mode no tuning takes place: the trigger completes at once, and two pulse inputs move the lane power-state field between its on and off codes. A bus error stops the run where it is and is reported on `error`.

Top module: `lane_tune_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high) `busy`, `done`, `error`, `bus_rd` and `bus_wr` are low and `cfg0`, `cfg1`, `cfg2` hold their reset parameter values (default zero).
- R2: A run is accepted once automatically in the first idle cycle after reset release and on every `start` pulse seen while idle; a `start` seen while `busy` is high is dropped and does not cause a second run.
- R3: In USB3 mode (`mode_pcie` low at acceptance) the run sets `cfg0[6:5]` to 2'b11 before the first bus request, and that field stays set while any bus read is issued.
- R4: The bus steps run in this order, as address / mask / value: 0x102D / 0x0080 / 0x0080; 0x1010 / 0x0FF0 / 0x0014; 0x1006 / 0x0FC0 / 0x0B80; 0x1002 / 0x7FFF / 0x4B7F; 0x0030 / 0x00F0 / 0x0080.
- R5: Each step reads the register, forms (old & ~mask) | (value & mask) and writes that back to the same address; the write is left out when the merged word equals the old word.
- R6: A bus request holds `bus_rd` or `bus_wr` (never both) with a stable `bus_addr` and `bus_wdata` until a cycle with `bus_done` or `bus_err` high, and drops in the following cycle.
- R7: After the fifth step the block sets `cfg2[20:18]` to 4, `cfg1[23:21]` to 4 and `cfg1[20:16]` to 9, then lowers `busy` and raises `done`.
- R8: A response with `bus_err` high ends the run: no further bus request is made, `error` goes high, `done` stays low, `busy` drops and the `cfg1`/`cfg2` tuning fields are left unchanged.
- R9: In PCIe mode an accepted trigger raises `done` in the next cycle with no bus access and no change to the configuration words.
- R10: In PCIe mode a `pwr_on` pulse writes 0x1C and a `pwr_off` pulse writes 0x1D into `cfg0[4:0]`, with `pwr_off` winning when both are high; in USB3 mode both pulses are ignored.
- R11: `done` and `error` hold their value until the next accepted trigger, which clears both in the cycle it is accepted; `done` is never high together with `busy` or `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Trigger pulse for a new run |
| mode_pcie | input | 1 | 1 = PCIe lane mode, 0 = USB3 lane mode |
| pwr_on | input | 1 | PCIe power-on pulse |
| pwr_off | input | 1 | PCIe power-off pulse |
| bus_rd | output | 1 | Control-bus read request |
| bus_wr | output | 1 | Control-bus write request |
| bus_addr | output | 16 | Control-bus register address |
| bus_wdata | output | 16 | Control-bus write data |
| bus_rdata | input | 16 | Control-bus read data, valid with bus_done |
| bus_done | input | 1 | Control-bus transfer complete |
| bus_err | input | 1 | Control-bus transfer failed |
| cfg0 | output | 32 | Local configuration word 0 (power state, protocol select) |
| cfg1 | output | 32 | Local configuration word 1 (loss-of-signal tuning) |
| cfg2 | output | 32 | Local configuration word 2 (transmit boost) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished cleanly |
| error | output | 1 | Last run aborted on a bus error |

## Verification
A trigger sampled at one rising edge shows on `busy` (USB3) or `done` (PCIe) at the next edge, and a power pulse shows in `cfg0[4:0]` one edge later; the bench drives these pulses on falling edges and reads the outputs on the falling edge after the sampling edge. Bus responses arrive a fixed number of cycles after a request is seen, so total run length varies with skipped writes; the bench therefore waits for `busy` low with `done` or `error` high and checks the final register contents, the read order and the transfer counts rather than fixed cycle numbers. Ignored stimuli (a `start` while busy, power pulses in USB3 mode, bus activity after an error) are checked by waiting a further stretch of cycles and then reading the transfer counters and configuration words.

// File: rtl/lane_tune_pkg.sv
package lane_tune_pkg;

  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int CW    = 32;
  localparam int NSTEP = 5;
  localparam int SW    = $clog2(NSTEP);

  // configuration field positions
  localparam int PWR_LSB   = 0;
  localparam int PWR_W     = 5;
  localparam int PSEL_LSB  = 5;
  localparam int PSEL_W    = 2;
  localparam int LVL_LSB   = 16;
  localparam int LVL_W     = 5;
  localparam int BIAS_LSB  = 21;
  localparam int BIAS_W    = 3;
  localparam int BOOST_LSB = 18;
  localparam int BOOST_W   = 3;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] mask;
    logic [DW-1:0] val;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_READ,
    ST_WAIT_RD,
    ST_MERGE,
    ST_WAIT_WR,
    ST_LOCAL
  } seq_state_t;

  function automatic step_t step_lookup(input logic [SW-1:0] idx);
    step_t s;
    case (idx)
      0:       s = '{addr: 16'h102D, mask: 16'h0080, val: 16'h0080};
      1:       s = '{addr: 16'h1010, mask: 16'h0FF0, val: 16'h0014};
      2:       s = '{addr: 16'h1006, mask: 16'h0FC0, val: 16'h0B80};
      3:       s = '{addr: 16'h1002, mask: 16'h7FFF, val: 16'h4B7F};
      default: s = '{addr: 16'h0030, mask: 16'h00F0, val: 16'h0080};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lane_step_rom.sv
module lane_step_rom
  import lane_tune_pkg::*;
#(
  parameter int N_STEPS = NSTEP,
  parameter int IDX_W   = SW
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            entry,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STEPS - 1);

  always_comb begin
    entry = step_lookup(idx);
    last  = (idx == LAST_IDX);
  end
endmodule

// File: rtl/lane_rmw_merge.sv
module lane_rmw_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] val,
  output logic [W-1:0] merged,
  output logic         changed
);
  always_comb begin
    merged  = (old_val & ~mask) | (val & mask);
    changed = (merged != old_val);
  end
endmodule

// File: rtl/lane_cr_master.sv
module lane_cr_master #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_done,
  input  logic          bus_err,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [DW-1:0] resp_data
);
  logic active;
  assign active = bus_rd | bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd     <= 1'b0;
      bus_wr     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (active) begin
        if (bus_done || bus_err) begin
          bus_rd     <= 1'b0;
          bus_wr     <= 1'b0;
          resp_valid <= 1'b1;
          resp_err   <= bus_err;
          resp_data  <= bus_rdata;
        end
      end else if (cmd_go) begin
        bus_rd    <= ~cmd_wr;
        bus_wr    <= cmd_wr;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end
    end
  end
endmodule

// File: rtl/lane_tune_seq.sv
module lane_tune_seq
  import lane_tune_pkg::*;
#(
  parameter logic [CW-1:0]      CFG0_RST     = '0,
  parameter logic [CW-1:0]      CFG1_RST     = '0,
  parameter logic [CW-1:0]      CFG2_RST     = '0,
  parameter logic [PWR_W-1:0]   PWR_ON_CODE  = 5'h1C,
  parameter logic [PWR_W-1:0]   PWR_OFF_CODE = 5'h1D,
  parameter logic [BOOST_W-1:0] BOOST_SET    = 3'd4,
  parameter logic [BIAS_W-1:0]  LOS_BIAS_SET = 3'd4,
  parameter logic [LVL_W-1:0]   LOS_LVL_SET  = 5'd9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_pcie,
  input  logic          pwr_on,
  input  logic          pwr_off,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_done,
  input  logic          bus_err,
  output logic [CW-1:0] cfg0,
  output logic [CW-1:0] cfg1,
  output logic [CW-1:0] cfg2,
  output logic          busy,
  output logic          done,
  output logic          error
);
  seq_state_t    state;
  logic [SW-1:0] step_idx;
  logic [DW-1:0] old_q;
  logic          auto_pend;
  logic          cmd_go, cmd_wr;
  logic          resp_valid, resp_err;
  logic [DW-1:0] resp_data;
  step_t         entry;
  logic          last_step;
  logic [DW-1:0] merged;
  logic          changed;

  lane_step_rom #(.N_STEPS(NSTEP), .IDX_W(SW)) u_rom (
    .idx   (step_idx),
    .entry (entry),
    .last  (last_step)
  );

  lane_rmw_merge #(.W(DW)) u_merge (
    .old_val (old_q),
    .mask    (entry.mask),
    .val     (entry.val),
    .merged  (merged),
    .changed (changed)
  );

  assign cmd_go = (state == ST_READ) || ((state == ST_MERGE) && changed);
  assign cmd_wr = (state == ST_MERGE);

  lane_cr_master #(.AW(AW), .DW(DW)) u_master (
    .clk        (clk),
    .rst        (rst),
    .cmd_go     (cmd_go),
    .cmd_wr     (cmd_wr),
    .cmd_addr   (entry.addr),
    .cmd_wdata  (merged),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_done   (bus_done),
    .bus_err    (bus_err),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_data  (resp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step_idx  <= '0;
      old_q     <= '0;
      auto_pend <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      cfg0      <= CFG0_RST;
      cfg1      <= CFG1_RST;
      cfg2      <= CFG2_RST;
    end else begin
      // power-state field, PCIe only, off has priority
      if (mode_pcie) begin
        if (pwr_off)
          cfg0[PWR_LSB +: PWR_W] <= PWR_OFF_CODE;
        else if (pwr_on)
          cfg0[PWR_LSB +: PWR_W] <= PWR_ON_CODE;
      end

      case (state)
        ST_IDLE: begin
          if (start || auto_pend) begin
            auto_pend <= 1'b0;
            error     <= 1'b0;
            if (mode_pcie) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              busy  <= 1'b1;
              state <= ST_SWITCH;
            end
          end
        end
        ST_SWITCH: begin
          cfg0[PSEL_LSB +: PSEL_W] <= '1;
          step_idx <= '0;
          state    <= ST_READ;
        end
        ST_READ: state <= ST_WAIT_RD;
        ST_WAIT_RD: begin
          if (resp_valid) begin
            if (resp_err) begin
              busy  <= 1'b0;
              error <= 1'b1;
              state <= ST_IDLE;
            end else begin
              old_q <= resp_data;
              state <= ST_MERGE;
            end
          end
        end
        ST_MERGE: begin
          if (changed)
            state <= ST_WAIT_WR;
          else if (last_step)
            state <= ST_LOCAL;
          else begin
            step_idx <= step_idx + 1'b1;
            state    <= ST_READ;
          end
        end
        ST_WAIT_WR: begin
          if (resp_valid) begin
            if (resp_err) begin
              busy  <= 1'b0;
              error <= 1'b1;
              state <= ST_IDLE;
            end else if (last_step) begin
              state <= ST_LOCAL;
            end else begin
              step_idx <= step_idx + 1'b1;
              state    <= ST_READ;
            end
          end
        end
        ST_LOCAL: begin
          cfg2[BOOST_LSB +: BOOST_W] <= BOOST_SET;
          cfg1[BIAS_LSB +: BIAS_W]   <= LOS_BIAS_SET;
          cfg1[LVL_LSB +: LVL_W]     <= LOS_LVL_SET;
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_tune_seq_chk.sv
module lane_tune_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_done,
  input logic          bus_err,
  input logic [CW-1:0] cfg0
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_done && !bus_err) |=> (bus_rd && $stable(bus_addr))); // R6

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_done && !bus_err) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata))); // R6

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && (bus_done || bus_err)) |=> (!bus_rd && !bus_wr)); // R6

  AST_NO_BUS_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_rd && !bus_wr)); // R8

  AST_SWITCH_FIRST: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> (cfg0[6:5] == 2'b11)); // R3

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R11

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R11

  AST_PWR_CODE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg0[4:0]) |-> (cfg0[4:0] == 5'h1C || cfg0[4:0] == 5'h1D)); // R10
endmodule

bind lane_tune_seq lane_tune_seq_chk #(.AW(16), .DW(16), .CW(32)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_done  (bus_done),
  .bus_err   (bus_err),
  .cfg0      (cfg0)
);

// File: tb/lane_tune_seq_test.sv
`timescale 1ns/1ps
module lane_tune_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, mode_pcie = 1'b0, pwr_on = 1'b0, pwr_off = 1'b0;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_done = 1'b0, bus_err = 1'b0;
  logic [31:0] cfg0, cfg1, cfg2;
  logic        busy, done, error;

  always #5 clk = ~clk;

  lane_tune_seq uut (
    .clk(clk), .rst(rst), .start(start), .mode_pcie(mode_pcie),
    .pwr_on(pwr_on), .pwr_off(pwr_off),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err),
    .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2),
    .busy(busy), .done(done), .error(error)
  );

  localparam logic [15:0] ADDRS [0:4] = '{16'h102D, 16'h1010, 16'h1006, 16'h1002, 16'h0030};
  // per vector: 5 initial words, 5 expected words, expected write count
  localparam logic [15:0] VEC [0:3][0:10] = '{
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
      16'h0080, 16'h0010, 16'h0B80, 16'h4B7F, 16'h0080, 16'd5},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
      16'hFFFF, 16'hF01F, 16'hFBBF, 16'hCB7F, 16'hFF8F, 16'd4},
    '{16'h0080, 16'h0010, 16'h0B80, 16'h4B7F, 16'h0080,
      16'h0080, 16'h0010, 16'h0B80, 16'h4B7F, 16'h0080, 16'd0},
    '{16'h5A5A, 16'hA5A5, 16'h1234, 16'h8001, 16'h0080,
      16'h5ADA, 16'hA015, 16'h1BB4, 16'hCB7F, 16'h0080, 16'd4}
  };
  localparam int LAT = 2;

  logic [15:0] mem [0:4];
  logic [15:0] rd_log [0:15];
  int rd_cnt = 0, wr_cnt = 0, xfer_cnt = 0, inj_at = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic int slot(input logic [15:0] a);
    for (int k = 0; k < 5; k++) if (ADDRS[k] == a) return k;
    return 5;
  endfunction

  // bus responder
  initial begin
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      if (bus_done || bus_err) begin
        bus_done = 1'b0;
        bus_err  = 1'b0;
        wc = 0;
      end else if ((bus_rd || bus_wr) && !rst) begin
        if (wc < LAT) wc++;
        else begin
          wc = 0;
          xfer_cnt++;
          if (xfer_cnt == inj_at) bus_err = 1'b1;
          else begin
            bus_done = 1'b1;
            if (bus_rd) begin
              bus_rdata = (slot(bus_addr) < 5) ? mem[slot(bus_addr)] : 16'h0;
              if (rd_cnt < 16) rd_log[rd_cnt] = bus_addr;
              rd_cnt++;
            end else begin
              if (slot(bus_addr) < 5) mem[slot(bus_addr)] = bus_wdata;
              wr_cnt++;
            end
          end
        end
      end else wc = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_cnt = 0; wr_cnt = 0; xfer_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while ((busy || !(done || error)) && n < 3000) begin
      @(negedge clk); n++;
    end
    if (n >= 3000) chk("R2 run timeout", 32'd1, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 5; k++) mem[k] = VEC[0][k];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done/error", {30'd0, done, error}, 32'd0);
    chk("R1 bus req", {30'd0, bus_rd, bus_wr}, 32'd0);
    chk("R1 cfg0", cfg0, 32'd0);
    chk("R1 cfg1|cfg2", cfg1 | cfg2, 32'd0);
    clear_logs();
    rst = 1'b0;

    // vector table: vector 0 runs through the automatic start
    for (int i = 0; i < 4; i++) begin
      bit order_ok;
      if (i > 0) begin
        for (int k = 0; k < 5; k++) mem[k] = VEC[i][k];
        clear_logs();
        pulse_start();
      end else @(negedge clk);
      wait_idle();
      for (int k = 0; k < 5; k++) chk($sformatf("R5 vec%0d word%0d", i, k), {16'd0, mem[k]}, {16'd0, VEC[i][5+k]});
      chk($sformatf("R5 vec%0d writes", i), wr_cnt, {16'd0, VEC[i][10]});
      chk($sformatf("R2 vec%0d reads", i), rd_cnt, 32'd5);
      order_ok = 1;
      for (int k = 0; k < 5; k++) if (rd_log[k] != ADDRS[k]) order_ok = 0;
      chk($sformatf("R4 vec%0d order", i), {31'd0, order_ok}, 32'd1);
      chk("R7 done/error/busy", {29'd0, done, error, busy}, 32'b100);
      chk("R3 protocol field", {30'd0, cfg0[6:5]}, 32'd3);
      chk("R7 cfg1", cfg1, 32'h0089_0000);
      chk("R7 cfg2", cfg2, 32'h0010_0000);
    end

    // R11: done holds
    repeat (20) @(negedge clk);
    chk("R11 done held", {31'd0, done}, 32'd1);

    // R2: start while busy is dropped
    for (int k = 0; k < 5; k++) mem[k] = 16'h0;
    clear_logs();
    pulse_start();
    chk("R11 done cleared by trigger", {30'd0, busy, done}, 32'b10);
    repeat (3) @(negedge clk);
    pulse_start();
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R2 busy start ignored", rd_cnt, 32'd5);

    // PCIe mode
    rst = 1'b1; mode_pcie = 1'b1;
    repeat (3) @(negedge clk);
    clear_logs();
    rst = 1'b0;
    @(negedge clk);
    chk("R9 auto done", {30'd0, done, busy}, 32'b10);
    repeat (10) @(negedge clk);
    chk("R9 no bus", xfer_cnt, 32'd0);
    chk("R9 cfg unchanged", cfg0 | cfg1 | cfg2, 32'd0);
    @(negedge clk); pwr_on = 1'b1;
    @(negedge clk); pwr_on = 1'b0;
    chk("R10 power on", {27'd0, cfg0[4:0]}, 32'h1C);
    pwr_on = 1'b1; pwr_off = 1'b1;
    @(negedge clk); pwr_on = 1'b0; pwr_off = 1'b0;
    chk("R10 off wins", {27'd0, cfg0[4:0]}, 32'h1D);
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R9 trigger done", {30'd0, done, busy}, 32'b10);
    chk("R9 trigger no bus", xfer_cnt, 32'd0);

    // USB3 with bus error on third transfer
    mode_pcie = 1'b0;
    @(negedge clk); pwr_on = 1'b1;
    @(negedge clk); pwr_on = 1'b0;
    chk("R10 ignored in USB3", {27'd0, cfg0[4:0]}, 32'h1D);
    for (int k = 0; k < 5; k++) mem[k] = 16'h0;
    clear_logs();
    inj_at = 3;
    pulse_start();
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R8 flags", {29'd0, done, error, busy}, 32'b010);
    chk("R8 transfers stop", xfer_cnt, 32'd3);
    chk("R8 tuning untouched", cfg1 | cfg2, 32'd0);
    chk("R3 switch before bus", {30'd0, cfg0[6:5]}, 32'd3);

    // R11: next trigger clears error
    inj_at = 0;
    clear_logs();
    pulse_start();
    chk("R11 error cleared", {30'd0, error, busy}, 32'b01);
    wait_idle();
    chk("R11 clean rerun", {30'd0, done, error}, 32'b10);

    finish_run();
  end
endmodule